// File: doc/BRIEF.md
# Slave Control Acceptance and Lock Manager

This block sits in the slave side of a multi-master serial bus controller. Once per frame the bit-level receiver hands it a decoded control field: the sender's 12-bit unit address, a broadcast flag, the 4-bit control code and the parity result. The block also sees the current empty flags of the local transmit and receive buffers. It answers with an acknowledge decision one cycle later. It then answers the message length field in the same way, and records enough context about the frame to act on the frame-end event.

Across frames it keeps a lock. A master can reserve the unit for a multi-frame transfer, and while the lock is held the block refuses data-moving codes from every other master. The block stores the owner's address and builds the bytes that a read of the status or of the lock address returns.

Every input event is a single-cycle strobe. The block accepts one strobe on any cycle and has no back-pressure, so it has no ready signal. The strobes `ctl_valid`, `len_valid` and `frame_end` must not arrive in the same cycle. Each answer appears on the cycle after its strobe, with a matching one-cycle valid.

Top module: `ctl_lock_mgr`

## Requirements
- R1: Control codes 1h, 2h, 8h, 9h, Ch and Dh are never acknowledged.
- R2: A control field whose parity check failed (`ctl_par_ok`=0) is not acknowledged.
- R3: While locked, codes 3h, 6h, 7h, Ah, Bh, Eh and Fh from a master whose address differs from the lock owner are refused. Codes 0h, 4h and 5h are still accepted from such a master, and the owner keeps full access.
- R4: Code 4h (lock address low byte) is refused while unlocked and accepted while locked.
- R5: A write code (bit 3 of the code set) is refused when the receive buffer is not empty. Codes 3h and 7h are refused when the transmit buffer is empty.
- R6: `ctl_ack_vld` pulses in the cycle after `ctl_valid`, and `ctl_ack` carries the decision in that same cycle. A broadcast frame (`bcast`=1) never drives `ctl_ack`=1.
- R7: `len_ack_vld` pulses in the cycle after `len_valid`. `len_ack` is 1 only if the control field of the current frame was accepted, the frame is not broadcast and the length parity is good.
- R8: A frame with code 3h, Ah or Bh whose length field was acknowledged, and that ends with `frame_full`=0, locks the unit from the cycle after `frame_end` and stores the sender as owner.
- R9: A frame with code 3h, Ah, Bh or 6h whose length field was acknowledged, and that ends with `frame_full`=1, leaves the unit unlocked. No other frame clears the lock.
- R10: Broadcast frames never change the lock state or the owner.
- R11: The status byte has bit 0 = transmit buffer not empty, bit 1 = receive buffer not empty and bit 2 = locked. All other bits are 0.
- R12: The lock address low byte is owner bits 7:0. The high byte is owner bits 11:8 in bits 3:0, with bits 7:4 set to 0. `reply_byte` returns the status byte for codes 0h and 6h, the low byte for code 4h, the high byte for code 5h, and 0 otherwise, selected by the current frame's control code.
- R13: `init_clr`=1 forces the unit unlocked on the next cycle and discards the current frame's context.
- R14: After reset the unit is unlocked, the owner is 0 and both acknowledge valids are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_clr | input | 1 | Local clear: unlock and drop frame context |
| ctl_valid | input | 1 | Control field received strobe |
| ctl_code | input | 4 | Received control code |
| master_addr | input | 12 | Sender unit address of the current frame |
| bcast | input | 1 | 1 = broadcast frame |
| ctl_par_ok | input | 1 | Control field parity good |
| txbuf_empty | input | 1 | Local transmit buffer empty |
| rxbuf_empty | input | 1 | Local receive buffer empty |
| len_valid | input | 1 | Message length field received strobe |
| len_par_ok | input | 1 | Length field parity good |
| frame_end | input | 1 | Frame finished strobe |
| frame_full | input | 1 | With frame_end: full byte count transferred |
| ctl_ack_vld | output | 1 | Control decision valid |
| ctl_ack | output | 1 | 1 = acknowledge the control field |
| len_ack_vld | output | 1 | Length decision valid |
| len_ack | output | 1 | 1 = acknowledge the length field |
| locked | output | 1 | Lock held |
| lock_owner | output | 12 | Address of the lock owner |
| status_byte | output | 8 | Slave status byte |
| lock_lo_byte | output | 8 | Lock address low byte |
| lock_hi_byte | output | 8 | Lock address high byte |
| reply_byte | output | 8 | Byte to return for the current read code |

## Verification
A wrong lock bit or a wrong owner register stays hidden until the next frame from a different master. It then shows as a wrong acknowledge one cycle after the control strobe. It also shows at once on `status_byte` bit 2 and on the lock address bytes. For that reason, every lock change is followed by a foreign-master request, an owner request and a direct read of the status and address bytes. A frame context that is stale or not cleared shows one cycle after the next length strobe as a spurious length acknowledge. At frame end it shows as a lock that appears or vanishes.

// File: rtl/ctl_lock_pkg.sv
package ctl_lock_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] C_RD_STAT  = 4'h0;
  localparam logic [CODE_W-1:0] C_RD_LKDAT = 4'h3;
  localparam logic [CODE_W-1:0] C_RD_LA_LO = 4'h4;
  localparam logic [CODE_W-1:0] C_RD_LA_HI = 4'h5;
  localparam logic [CODE_W-1:0] C_RD_UNLK  = 4'h6;
  localparam logic [CODE_W-1:0] C_RD_DATA  = 4'h7;
  localparam logic [CODE_W-1:0] C_WR_LKCMD = 4'hA;
  localparam logic [CODE_W-1:0] C_WR_LKDAT = 4'hB;
  localparam logic [CODE_W-1:0] C_WR_CMD   = 4'hE;
  localparam logic [CODE_W-1:0] C_WR_DATA  = 4'hF;

  function automatic logic code_known(input logic [CODE_W-1:0] c);
    case (c)
      C_RD_STAT, C_RD_LKDAT, C_RD_LA_LO, C_RD_LA_HI, C_RD_UNLK,
      C_RD_DATA, C_WR_LKCMD, C_WR_LKDAT, C_WR_CMD, C_WR_DATA: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // codes reserved to the lock owner while a lock is held
  function automatic logic code_owner_only(input logic [CODE_W-1:0] c);
    case (c)
      C_RD_LKDAT, C_RD_UNLK, C_RD_DATA, C_WR_LKCMD,
      C_WR_LKDAT, C_WR_CMD, C_WR_DATA: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic code_sets_lock(input logic [CODE_W-1:0] c);
    return (c == C_RD_LKDAT) || (c == C_WR_LKCMD) || (c == C_WR_LKDAT);
  endfunction

  function automatic logic code_clears_lock(input logic [CODE_W-1:0] c);
    return code_sets_lock(c) || (c == C_RD_UNLK);
  endfunction

  function automatic logic code_reads_buf(input logic [CODE_W-1:0] c);
    return (c == C_RD_LKDAT) || (c == C_RD_DATA);
  endfunction
endpackage

// File: rtl/clm_ctl_judge.sv
module clm_ctl_judge
  import ctl_lock_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_valid,
  input  logic [CODE_W-1:0] code,
  input  logic [ADDR_W-1:0] master,
  input  logic              bcast,
  input  logic              par_ok,
  input  logic              txe,
  input  logic              rxe,
  input  logic              locked,
  input  logic [ADDR_W-1:0] owner,
  output logic              accept,
  output logic              ack_vld,
  output logic              ack
);
  logic foreign, refuse;

  always_comb begin
    foreign = locked && (master != owner);
    refuse  = !par_ok
           || !code_known(code)
           || (foreign && code_owner_only(code))
           || ((code == C_RD_LA_LO) && !locked)
           || (code[CODE_W-1] && !rxe)
           || (code_reads_buf(code) && txe);
    accept  = !refuse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_vld <= 1'b0;
      ack     <= 1'b0;
    end else begin
      ack_vld <= ctl_valid;
      ack     <= ctl_valid && accept && !bcast;
    end
  end

  // R1
  undef_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && (code == 4'h1 || code == 4'h2 || code == 4'h8 ||
                  code == 4'h9 || code == 4'hC || code == 4'hD) |=> !ack);
  // R4
  la_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && (code == 4'h4) && !locked |=> !ack);
  // R6
  bcast_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && bcast |=> ack_vld && !ack);
  // R3
  foreign_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && locked && (master != owner) && (code == 4'h7) |=> !ack);
endmodule

// File: rtl/clm_frame_ctx.sv
module clm_frame_ctx
  import ctl_lock_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_clr,
  input  logic              ctl_valid,
  input  logic              accept,
  input  logic [CODE_W-1:0] code,
  input  logic [ADDR_W-1:0] master,
  input  logic              bcast,
  input  logic              len_valid,
  input  logic              len_par_ok,
  input  logic              frame_end,
  output logic              len_ack_vld,
  output logic              len_ack,
  output logic [CODE_W-1:0] ctx_code,
  output logic [ADDR_W-1:0] ctx_master,
  output logic              ctx_bcast,
  output logic              ctx_len_ok
);
  logic ctx_acc;
  logic len_good;

  assign len_good = ctx_acc && !ctx_bcast && len_par_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_code    <= '0;
      ctx_master  <= '0;
      ctx_bcast   <= 1'b0;
      ctx_acc     <= 1'b0;
      ctx_len_ok  <= 1'b0;
      len_ack_vld <= 1'b0;
      len_ack     <= 1'b0;
    end else begin
      len_ack_vld <= len_valid && !init_clr;
      len_ack     <= len_valid && !init_clr && len_good;
      if (init_clr || frame_end) begin
        ctx_acc    <= 1'b0;
        ctx_len_ok <= 1'b0;
        ctx_bcast  <= 1'b0;
      end else if (ctl_valid) begin
        ctx_code   <= code;
        ctx_master <= master;
        ctx_bcast  <= bcast;
        ctx_acc    <= accept;
        ctx_len_ok <= 1'b0;
      end else if (len_valid) begin
        ctx_len_ok <= len_good;
      end
    end
  end

  // R7
  len_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_valid && !len_par_ok |=> !len_ack);
  // R7
  len_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_ack |-> len_ack_vld);
endmodule

// File: rtl/clm_lock_reg.sv
module clm_lock_reg
  import ctl_lock_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_clr,
  input  logic              frame_end,
  input  logic              frame_full,
  input  logic [CODE_W-1:0] ctx_code,
  input  logic [ADDR_W-1:0] ctx_master,
  input  logic              ctx_bcast,
  input  logic              ctx_len_ok,
  output logic              locked,
  output logic [ADDR_W-1:0] owner
);
  logic eligible, do_set, do_clr;

  always_comb begin
    eligible = frame_end && ctx_len_ok && !ctx_bcast;
    do_set   = eligible && !frame_full && code_sets_lock(ctx_code);
    do_clr   = eligible &&  frame_full && code_clears_lock(ctx_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      owner  <= '0;
    end else if (init_clr) begin
      locked <= 1'b0;
    end else if (do_set) begin
      locked <= 1'b1;
      owner  <= ctx_master;
    end else if (do_clr) begin
      locked <= 1'b0;
    end
  end

  // R13
  clr_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr |=> !locked);
  // R10
  bcast_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && ctx_bcast && !init_clr |=> $stable(locked) && $stable(owner));
  // R8
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(frame_end && !frame_full));
  // R9
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(init_clr || (frame_end && frame_full)));
endmodule

// File: rtl/ctl_lock_mgr.sv
module ctl_lock_mgr
  import ctl_lock_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_clr,
  input  logic              ctl_valid,
  input  logic [CODE_W-1:0] ctl_code,
  input  logic [ADDR_W-1:0] master_addr,
  input  logic              bcast,
  input  logic              ctl_par_ok,
  input  logic              txbuf_empty,
  input  logic              rxbuf_empty,
  input  logic              len_valid,
  input  logic              len_par_ok,
  input  logic              frame_end,
  input  logic              frame_full,
  output logic              ctl_ack_vld,
  output logic              ctl_ack,
  output logic              len_ack_vld,
  output logic              len_ack,
  output logic              locked,
  output logic [ADDR_W-1:0] lock_owner,
  output logic [BYTE_W-1:0] status_byte,
  output logic [BYTE_W-1:0] lock_lo_byte,
  output logic [BYTE_W-1:0] lock_hi_byte,
  output logic [BYTE_W-1:0] reply_byte
);
  localparam int HI_W = ADDR_W - BYTE_W;

  logic              accept;
  logic [CODE_W-1:0] ctx_code;
  logic [ADDR_W-1:0] ctx_master;
  logic              ctx_bcast, ctx_len_ok;

  clm_ctl_judge #(.ADDR_W(ADDR_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .code(ctl_code),
    .master(master_addr), .bcast(bcast), .par_ok(ctl_par_ok),
    .txe(txbuf_empty), .rxe(rxbuf_empty), .locked(locked), .owner(lock_owner),
    .accept(accept), .ack_vld(ctl_ack_vld), .ack(ctl_ack)
  );

  clm_frame_ctx #(.ADDR_W(ADDR_W)) u_ctx (
    .clk(clk), .rst_n(rst_n), .init_clr(init_clr), .ctl_valid(ctl_valid),
    .accept(accept), .code(ctl_code), .master(master_addr), .bcast(bcast),
    .len_valid(len_valid), .len_par_ok(len_par_ok), .frame_end(frame_end),
    .len_ack_vld(len_ack_vld), .len_ack(len_ack), .ctx_code(ctx_code),
    .ctx_master(ctx_master), .ctx_bcast(ctx_bcast), .ctx_len_ok(ctx_len_ok)
  );

  clm_lock_reg #(.ADDR_W(ADDR_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .init_clr(init_clr), .frame_end(frame_end),
    .frame_full(frame_full), .ctx_code(ctx_code), .ctx_master(ctx_master),
    .ctx_bcast(ctx_bcast), .ctx_len_ok(ctx_len_ok),
    .locked(locked), .owner(lock_owner)
  );

  always_comb begin
    status_byte    = '0;
    status_byte[0] = !txbuf_empty;
    status_byte[1] = !rxbuf_empty;
    status_byte[2] = locked;
    lock_lo_byte   = lock_owner[BYTE_W-1:0];
    lock_hi_byte   = {{(BYTE_W-HI_W){1'b0}}, lock_owner[ADDR_W-1:BYTE_W]};
    case (ctx_code)
      C_RD_STAT, C_RD_UNLK: reply_byte = status_byte;
      C_RD_LA_LO:           reply_byte = lock_lo_byte;
      C_RD_LA_HI:           reply_byte = lock_hi_byte;
      default:              reply_byte = '0;
    endcase
  end

  // R12
  hi_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hi_byte[BYTE_W-1:HI_W] == '0);
  // R11
  status_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[BYTE_W-1:3] == '0);
endmodule

// File: tb/ctl_lock_mgr_tb.sv
`timescale 1ns/1ps
module ctl_lock_mgr_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_clr = 0, ctl_valid = 0, bcast = 0, ctl_par_ok = 1;
  logic [3:0] ctl_code = 0;
  logic [11:0] master_addr = 0;
  logic txbuf_empty = 1, rxbuf_empty = 1;
  logic len_valid = 0, len_par_ok = 1, frame_end = 0, frame_full = 0;
  logic ctl_ack_vld, ctl_ack, len_ack_vld, len_ack, locked;
  logic [11:0] lock_owner;
  logic [7:0] status_byte, lock_lo_byte, lock_hi_byte, reply_byte;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctl_lock_mgr u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // control field; returns after the answer cycle, at a negedge
  task automatic ctl(input logic [3:0] c, input logic [11:0] m, input logic b,
                     input logic p, input logic exp, input string tag);
    ctl_code = c; master_addr = m; bcast = b; ctl_par_ok = p; ctl_valid = 1;
    @(negedge clk);
    ctl_valid = 0;
    chk({tag, " vld"}, ctl_ack_vld, 1);
    chk(tag, ctl_ack, exp);
  endtask

  task automatic len(input logic p, input logic exp, input string tag);
    len_par_ok = p; len_valid = 1;
    @(negedge clk);
    len_valid = 0;
    chk({tag, " vld"}, len_ack_vld, 1);
    chk(tag, len_ack, exp);
  endtask

  task automatic fend(input logic full);
    frame_full = full; frame_end = 1;
    @(negedge clk);
    frame_end = 0; frame_full = 0;
  endtask

  task automatic t_reset();
    chk("R14 locked", locked, 0);
    chk("R14 owner", lock_owner, 0);
    chk("R14 ctl vld", ctl_ack_vld, 0);
    chk("R14 len vld", len_ack_vld, 0);
    chk("R11 status idle", status_byte, 8'h00);
  endtask

  task automatic t_codes();
    foreach (u_codes[i]) ctl(u_codes[i], 12'h010, 0, 1, 0, "R1 undefined code");
    ctl(4'h0, 12'h010, 0, 0, 0, "R2 bad parity");
    ctl(4'h0, 12'h010, 0, 1, 1, "R2 good parity");
    ctl(4'h4, 12'h010, 0, 1, 0, "R4 lock addr unlocked");
    rxbuf_empty = 0;
    ctl(4'hF, 12'h010, 0, 1, 0, "R5 write rx busy");
    chk("R11 status rx", status_byte, 8'h02);
    rxbuf_empty = 1;
    ctl(4'hF, 12'h010, 0, 1, 1, "R5 write rx empty");
    ctl(4'h7, 12'h010, 0, 1, 0, "R5 read tx empty");
    ctl(4'h3, 12'h010, 0, 1, 0, "R5 read-lock tx empty");
    txbuf_empty = 0;
    ctl(4'h7, 12'h010, 0, 1, 1, "R5 read tx full");
    chk("R11 status tx", status_byte, 8'h01);
    txbuf_empty = 1;
    ctl(4'hF, 12'h010, 1, 1, 0, "R6 broadcast no ack");
  endtask

  logic [3:0] u_codes [6] = '{4'h1, 4'h2, 4'h8, 4'h9, 4'hC, 4'hD};

  task automatic t_len();
    ctl(4'h1, 12'h020, 0, 1, 0, "R7 ctl nak");
    len(1, 0, "R7 len after nak");
    ctl(4'hE, 12'h020, 0, 1, 1, "R7 ctl ack");
    len(0, 0, "R7 len bad parity");
    ctl(4'hE, 12'h020, 0, 1, 1, "R7 ctl ack");
    len(1, 1, "R7 len good");
    fend(1);
    ctl(4'hB, 12'h020, 0, 1, 1, "R8 ctl lock nolen");
    len(0, 0, "R8 len nak");
    fend(0);
    chk("R8 no lock without len ack", locked, 0);
    ctl(4'hA, 12'h020, 0, 1, 1, "R9 ctl full A");
    len(1, 1, "R9 len");
    fend(1);
    chk("R9 full frame no lock", locked, 0);
  endtask

  task automatic t_bcast();
    ctl(4'hB, 12'h030, 1, 1, 0, "R10 bcast ctl");
    len(1, 0, "R10 bcast len");
    fend(0);
    chk("R10 bcast no lock", locked, 0);
    chk("R10 bcast owner", lock_owner, 0);
  endtask

  task automatic t_lock();
    ctl(4'hB, 12'h123, 0, 1, 1, "R8 ctl B");
    len(1, 1, "R8 len");
    fend(0);
    chk("R8 locked", locked, 1);
    chk("R8 owner", lock_owner, 12'h123);
    chk("R11 status locked", status_byte, 8'h04);
    txbuf_empty = 0; rxbuf_empty = 0;
    #0.1 chk("R11 status all", status_byte, 8'h07);
    txbuf_empty = 1; rxbuf_empty = 1;
    chk("R12 lo", lock_lo_byte, 8'h23);
    chk("R12 hi", lock_hi_byte, 8'h01);
    ctl(4'h4, 12'h456, 0, 1, 1, "R4 lock addr locked foreign");
    chk("R12 reply lo", reply_byte, 8'h23);
    ctl(4'h5, 12'h456, 0, 1, 1, "R3 code5 foreign");
    chk("R12 reply hi", reply_byte, 8'h01);
    ctl(4'h0, 12'h456, 0, 1, 1, "R3 code0 foreign");
    chk("R12 reply status", reply_byte, 8'h04);
    ctl(4'hE, 12'h456, 0, 1, 0, "R3 foreign E");
    ctl(4'h6, 12'h456, 0, 1, 0, "R3 foreign 6");
    txbuf_empty = 0;
    ctl(4'h7, 12'h456, 0, 1, 0, "R3 foreign 7");
    ctl(4'h7, 12'h123, 0, 1, 1, "R3 owner 7");
    len(1, 1, "R9 owner 7 len");
    fend(1);
    chk("R9 code7 keeps lock", locked, 1);
    txbuf_empty = 1;
    ctl(4'h6, 12'h123, 0, 1, 1, "R9 owner 6");
    len(1, 1, "R9 len 6");
    fend(0);
    chk("R9 partial 6 keeps lock", locked, 1);
    ctl(4'h6, 12'h123, 0, 1, 1, "R9 owner 6 again");
    len(1, 1, "R9 len 6 again");
    fend(1);
    chk("R9 unlocked by 6", locked, 0);
  endtask

  task automatic t_relock();
    ctl(4'hA, 12'h0AB, 0, 1, 1, "R8 ctl A");
    len(1, 1, "R8 len A");
    fend(0);
    chk("R8 locked A", locked, 1);
    chk("R8 owner A", lock_owner, 12'h0AB);
    ctl(4'hB, 12'h123, 0, 1, 0, "R3 foreign B");
    len(1, 0, "R7 len after foreign nak");
    fend(0);
    chk("R3 owner kept", lock_owner, 12'h0AB);
    txbuf_empty = 0;
    ctl(4'h3, 12'h0AB, 0, 1, 1, "R9 owner 3");
    len(1, 1, "R9 len 3");
    fend(1);
    chk("R9 unlocked by 3", locked, 0);
    ctl(4'h3, 12'h0AB, 0, 1, 1, "R13 ctl 3");
    len(1, 1, "R13 len 3");
    fend(0);
    chk("R13 locked before clr", locked, 1);
    txbuf_empty = 1;
    init_clr = 1;
    @(negedge clk);
    init_clr = 0;
    chk("R13 cleared", locked, 0);
    ctl(4'hE, 12'h777, 0, 1, 1, "R13 foreign accepted after clr");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_codes();
    t_len();
    t_bcast();
    t_lock();
    t_relock();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule